// File: doc/BRIEF.md
# Serially Loaded Crosspoint Routing Switch

This block routes signals between two groups of seven pins, group A and group B. Each pin either stays an input or drives the signal of one chosen pin in the other group. A host builds the routing as a 56-bit configuration word. It writes that word one bit per bus write into a shadow register. A separate strobe write then copies the whole shadow word into the active configuration in one clock edge, so every route changes together.

Pad behaviour is not part of the block. Each pin is brought out as three wires: the value it receives, the value it would drive, and an output-enable flag. The pad ring combines these into a bidirectional pin. The configuration holds fourteen 4-bit fields, one for each pin. A source number that names no pin produces a constant low.

Top module: `routing_xbar`

## Requirements
- R1: After reset, every `a_oe` and `b_oe` bit is 0 and every `a_out` and `b_out` bit is 0.
- R2: A shift write (`wr_en`=1, `wr_addr`=0) takes only `wr_data[0]`. Bits 7..1 of `wr_data` have no effect on the resulting routing.
- R3: Configuration bit i is the value delivered by the i-th shift write of a 56-write sequence, counting from 0.
  - Field k occupies bits 4k+3..4k.
  - Fields 0..6 belong to group A pins 0..6, and fields 7..13 belong to group B pins 0..6.
  - In each field, bits 2..0 are the source number and bit 3 is the output enable.
- R4: A strobe write (`wr_en`=1, `wr_addr`=1) with any `wr_data` value copies the shadow word into the active configuration. The outputs show the new routing from the clock edge that captures the write.
- R5: Shift writes change only the shadow word. The outputs and enables keep the previous routing until the next strobe.
- R6: An enabled group A pin drives `b_in[s]` on `a_out`. An enabled group B pin drives `a_in[s]` on `b_out`. Here s is the field's source number, and the path is combinational from the inputs.
- R7: An enabled pin whose source number is 7, which names no pin, drives 0.
- R8: A pin whose output-enable bit is 0 shows `oe`=0 and `out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears shadow and active words |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| wr_addr | input | 1 | 0 selects the shift register, 1 selects the strobe |
| wr_data | input | 8 | Host write data; only bit 0 matters for shifts |
| a_in | input | 7 | Values received on group A pins |
| b_in | input | 7 | Values received on group B pins |
| a_out | output | 7 | Values to drive on group A pins |
| a_oe | output | 7 | Output enables of group A pins |
| b_out | output | 7 | Values to drive on group B pins |
| b_oe | output | 7 | Output enables of group B pins |

## Verification
The bench uses the default parameters: seven pins per group and a 3-bit source number. This gives the full 56-bit word and a source code of 7 that names no pin, so the constant-low path can be reached. Random words are shifted in with random upper data bits. The bench checks that nothing changes before the strobe, then compares the outputs with a model under several input vectors. Directed words isolate the ordering of the first field, the no-pin code and the all-disabled case.

// File: rtl/routing_xbar.sv
module routing_xbar #(
  parameter int PINS = 7,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [PINS-1:0] a_in,
  input  logic [PINS-1:0] b_in,
  output logic [PINS-1:0] a_out,
  output logic [PINS-1:0] a_oe,
  output logic [PINS-1:0] b_out,
  output logic [PINS-1:0] b_oe
);
  localparam int FW = SELW + 1;
  localparam int NF = 2 * PINS;
  localparam int PW = NF * FW;
  localparam int NS = 1 << SELW;

  logic [PW-1:0] shadow_q, active_q;
  logic [NS-1:0] a_ext, b_ext;

  wire shift_wr  = wr_en & ~wr_addr;
  wire strobe_wr = wr_en & wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_wr)  shadow_q <= {wr_data[0], shadow_q[PW-1:1]};
      if (strobe_wr) active_q <= shadow_q;
    end
  end

  always_comb begin
    a_ext = '0;
    b_ext = '0;
    a_ext[PINS-1:0] = a_in;
    b_ext[PINS-1:0] = b_in;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    wire [SELW-1:0] sel_a = active_q[i*FW +: SELW];
    wire            en_a  = active_q[i*FW + SELW];
    wire [SELW-1:0] sel_b = active_q[(i+PINS)*FW +: SELW];
    wire            en_b  = active_q[(i+PINS)*FW + SELW];

    assign a_oe[i]  = en_a;
    assign a_out[i] = en_a & b_ext[sel_a];
    assign b_oe[i]  = en_b;
    assign b_out[i] = en_b & a_ext[sel_b];

    a_r7_nopin_a: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[i] && int'(sel_a) >= PINS) |-> !a_out[i]);
    a_r7_nopin_b: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[i] && int'(sel_b) >= PINS) |-> !b_out[i]);
    a_r8_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
      !a_oe[i] |-> !a_out[i]);
    a_r8_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
      !b_oe[i] |-> !b_out[i]);
  end

  a_r2_shift_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    shift_wr |=> shadow_q[PW-1] == $past(wr_data[0]));
  a_r4_strobe_copy: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_wr |=> active_q == $past(shadow_q));
  a_r5_hold_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_wr |=> $stable({a_oe, b_oe}));
endmodule

// File: tb/sim_routing_xbar.sv
module sim_routing_xbar;
  localparam int PINS = 7;
  localparam int PW = 56;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [PINS-1:0] a_in = 0, b_in = 0, a_out, a_oe, b_out, b_oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  routing_xbar u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .a_in, .b_in,
                   .a_out, .a_oe, .b_out, .b_oe);

  function automatic logic [27:0] model(input logic [PW-1:0] p,
                                        input logic [PINS-1:0] ai, bi);
    logic [PINS-1:0] ao, ae, bo, be;
    for (int k = 0; k < PINS; k++) begin
      logic [3:0] fa, fb;
      fa = p[4*k +: 4];
      fb = p[4*(k+PINS) +: 4];
      ae[k] = fa[3];
      be[k] = fb[3];
      ao[k] = fa[3] && fa[2:0] != 3'd7 ? bi[fa[2:0]] : 1'b0;
      bo[k] = fb[3] && fb[2:0] != 3'd7 ? ai[fb[2:0]] : 1'b0;
    end
    return {ao, ae, bo, be};
  endfunction

  task automatic wr(input logic addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 8'($urandom);
  endtask

  task automatic shift_in(input logic [PW-1:0] p);
    for (int i = 0; i < PW; i++) wr(1'b0, {7'($urandom), p[i]});
  endtask

  task automatic check(input string req, input logic [PW-1:0] p);
    logic [27:0] got, exp;
    @(negedge clk);
    a_in = 7'($urandom); b_in = 7'($urandom);
    #1;
    got = {a_out, a_oe, b_out, b_oe};
    exp = model(p, a_in, b_in);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] cur, nxt, p;
    void'($urandom(32'd4711));
    cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset state", '0);
    check("R1 reset state", '0);

    // R2: data 8'hFE carries a 0 in bit 0, so every field stays disabled
    for (int i = 0; i < PW; i++) wr(1'b0, 8'hFE);
    wr(1'b1, 8'h00);
    check("R2 upper bits ignored", '0);

    // R3: only field 0 enabled, source 2, shifted first
    p = '0; p[3:0] = 4'b1010;
    shift_in(p);
    wr(1'b1, 8'h5A);
    cur = p;
    check("R3 first write is bit 0", cur);

    // R7: every field enabled with source 7
    p = {14{4'hF}};
    shift_in(p);
    check("R5 held before strobe", cur);
    wr(1'b1, 8'hFF);
    cur = p;
    check("R7 no-pin source drives 0", cur);
    check("R7 no-pin source drives 0", cur);

    for (int n = 0; n < 20; n++) begin
      nxt = {24'($urandom), $urandom};
      shift_in(nxt);
      check("R5 shift leaves routing", cur);
      wr(1'b1, 8'($urandom));
      cur = nxt;
      for (int j = 0; j < 4; j++) check("R4 R6 R8 routed outputs", cur);
    end

    // R8: fields enabled but then all disabled
    shift_in('0);
    wr(1'b1, 8'h01);
    cur = '0;
    check("R8 disabled pins", cur);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule